// File: doc/BRIEF.md
# Hardware Cursor Sprite Overlay

This block paints a 64 by 64 cursor sprite over an outgoing stream of 8-bit pixels. A host loads a 1024-byte pattern memory that holds two bit planes for each sprite row. Through a small register port it also sets two cursor colours, a hot-spot offset, a cursor position and an enable bit. Each cycle the display pipeline presents a beam coordinate and the background pixel at that coordinate. Two clocks later the block returns the pixel to display.

The host gives the cursor position in logical-screen coordinates. The display's current panning offset arrives on input ports, and the block subtracts both the hot spot and the pan to find the sprite's upper-left corner on the visible raster. The window arithmetic is signed. A corner pushed off the top or left edge therefore clips the sprite instead of wrapping it to the far side of the screen.

Inside the window, each pixel's two plane bits pick one of four results: either of the two colours, the background unchanged, or the background with every bit inverted.

Top module: `hwcur_overlay`

## Requirements
- R1: A synchronous active-high reset drives `px_out` to 0 and clears the enable bit, both colours, the hot spot and the position.
- R2: Each output pixel belongs to the beam inputs that were presented two rising clock edges earlier.
- R3: For sprite row r and column c, with c = 32*w + 8*k + b, the plane-p bit is bit (7 - b) of pattern byte r*16 + p*8 + w*4 + (3 - k). Each 32-bit plane word is stored lowest byte first, and the most significant bit of a byte is the leftmost pixel.
- R4: Inside the window, plane bits (plane0, plane1) = (0,0) output colour register 2, and (0,1) outputs colour register 1.
- R5: Plane bits (1,0) are transparent and output the background pixel unchanged.
- R6: Plane bits (1,1) output the background pixel XOR 0xFF.
- R7: The sprite corner is position minus hot spot minus pan on each axis. A beam coordinate is inside the window when beam minus corner lies in 0..63 on both axes. Outside the window the background passes through.
- R8: When the enable bit is clear, every pixel outputs the background pixel. Enable is clear after reset.
- R9: A corner made negative by the subtraction clips the sprite. Beam coordinates near the top of the coordinate range never hit a wrapped copy.
- R10: The register port decodes `cfg_sel` as 0 = enable (bit 0), 1 = colour 1, 2 = colour 2, 3 = hot-spot X (low 6 bits), 4 = hot-spot Y (low 6 bits), 5 = position X and 6 = position Y. A write with select 7 changes nothing.
- R11: When a pattern write and a fetch hit the same byte in the same cycle, the fetch returns the previous contents. Beam inputs presented in later cycles see the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_we | input | 1 | Pattern memory write strobe |
| pat_addr | input | 10 | Pattern byte address |
| pat_wdata | input | 8 | Pattern byte data |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 12 | Register write data |
| pan_x | input | 12 | Current horizontal panning offset |
| pan_y | input | 12 | Current vertical panning offset |
| beam_x | input | 12 | Beam column on the visible raster |
| beam_y | input | 12 | Beam row on the visible raster |
| bg_px | input | 8 | Background pixel at the beam |
| px_out | output | 8 | Composited pixel, two clocks after the beam inputs |

## Verification
A host pattern write can land in the same cycle as a fetch that reads the same byte for the pixel under the beam. The bench provokes this by parking the beam on one sprite pixel for several cycles and writing that pixel's byte partway through. The written value changes the pixel's plane code. The expected stream is computed from the old byte for the cycle of the write and from the new byte for every later cycle, and each output is compared two clocks after its beam inputs.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;
  parameter int SPR_DIM = 64;
  parameter int COORD_W = 12;
  parameter int PIX_W   = 8;

  localparam int BYTE_W      = 8;
  localparam int SPR_LOG     = $clog2(SPR_DIM);
  localparam int ROW_BYTES   = SPR_DIM / BYTE_W;
  localparam int PL_BIT      = $clog2(ROW_BYTES);
  localparam int BANK_DEPTH  = SPR_DIM * ROW_BYTES;
  localparam int BANK_AW     = $clog2(BANK_DEPTH);
  localparam int PAT_AW      = BANK_AW + 1;

  typedef enum logic [1:0] {
    CODE_COL2   = 2'b00,
    CODE_COL1   = 2'b01,
    CODE_CLEAR  = 2'b10,
    CODE_INVERT = 2'b11
  } code_e;

  typedef enum logic [2:0] {
    CFG_ENABLE = 3'd0,
    CFG_COL1   = 3'd1,
    CFG_COL2   = 3'd2,
    CFG_HOTX   = 3'd3,
    CFG_HOTY   = 3'd4,
    CFG_POSX   = 3'd5,
    CFG_POSY   = 3'd6
  } cfg_sel_e;

  // index inside one plane bank: row, 32-bit word, then byte lane
  // reversed because words are stored lowest byte first
  function automatic logic [BANK_AW-1:0] bank_index(
    input logic [SPR_LOG-1:0] row,
    input logic [SPR_LOG-1:0] col
  );
    return {row, col[SPR_LOG-1:5], ~col[4:3]};
  endfunction

  // select a pixel's bit from a byte: leftmost pixel sits in the MSB
  function automatic logic pick_bit(input logic [BYTE_W-1:0] b, input logic [2:0] pos);
    return b[~pos];
  endfunction
endpackage

// File: rtl/hwcur_cfg.sv
module hwcur_cfg
  import hwcur_pkg::*;
#(
  parameter int CW = hwcur_pkg::COORD_W,
  parameter int PW = hwcur_pkg::PIX_W,
  parameter int HW = hwcur_pkg::SPR_LOG
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_sel,
  input  logic [CW-1:0]        cfg_wdata,
  output logic                 en_q,
  output logic [PW-1:0]        col1_q,
  output logic [PW-1:0]        col2_q,
  output logic [1:0][HW-1:0]   hot_q,
  output logic [1:0][CW-1:0]   pos_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      col1_q <= '0;
      col2_q <= '0;
      hot_q  <= '0;
      pos_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        CFG_ENABLE: en_q      <= cfg_wdata[0];
        CFG_COL1:   col1_q    <= cfg_wdata[PW-1:0];
        CFG_COL2:   col2_q    <= cfg_wdata[PW-1:0];
        CFG_HOTX:   hot_q[0]  <= cfg_wdata[HW-1:0];
        CFG_HOTY:   hot_q[1]  <= cfg_wdata[HW-1:0];
        CFG_POSX:   pos_q[0]  <= cfg_wdata;
        CFG_POSY:   pos_q[1]  <= cfg_wdata;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/hwcur_window.sv
module hwcur_window
  import hwcur_pkg::*;
#(
  parameter int CW = hwcur_pkg::COORD_W,
  parameter int HW = hwcur_pkg::SPR_LOG
) (
  input  logic                     en,
  input  logic [1:0][CW-1:0]       beam,
  input  logic [1:0][CW-1:0]       pos,
  input  logic [1:0][CW-1:0]       pan,
  input  logic [1:0][HW-1:0]       hot,
  output logic                     hit,
  output logic [1:0][SPR_LOG-1:0]  offs
);
  localparam int SW = CW + 3;

  logic [1:0] axis_in;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    logic signed [SW-1:0] corner;
    logic signed [SW-1:0] delta;
    assign corner = $signed({3'b000, pos[a]})
                  - $signed({{(SW-HW){1'b0}}, hot[a]})
                  - $signed({3'b000, pan[a]});
    assign delta  = $signed({3'b000, beam[a]}) - corner;
    // inside when 0 <= delta < SPR_DIM: sign clear and upper bits zero
    assign axis_in[a] = (delta[SW-1:SPR_LOG] == '0);
    assign offs[a]    = delta[SPR_LOG-1:0];
  end

  assign hit = en & (&axis_in);
endmodule

// File: rtl/hwcur_patmem.sv
module hwcur_patmem
  import hwcur_pkg::*;
(
  input  logic                        clk,
  input  logic                        wr_en,
  input  logic [PAT_AW-1:0]           wr_addr,
  input  logic [BYTE_W-1:0]           wr_data,
  input  logic [BANK_AW-1:0]          rd_idx,
  output logic [1:0][BYTE_W-1:0]      rd_q
);
  logic [BANK_AW-1:0] wr_idx;
  assign wr_idx = {wr_addr[PAT_AW-1:PL_BIT+1], wr_addr[PL_BIT-1:0]};

  for (genvar p = 0; p < 2; p++) begin : g_plane
    logic [BYTE_W-1:0] bank [BANK_DEPTH];
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr[PL_BIT] == 1'(p))) bank[wr_idx] <= wr_data;
      q <= bank[rd_idx];
    end
    assign rd_q[p] = q;
  end
endmodule

// File: rtl/hwcur_shade.sv
module hwcur_shade
  import hwcur_pkg::*;
#(
  parameter int PW = hwcur_pkg::PIX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  code_e         code,
  input  logic [PW-1:0] bg,
  input  logic [PW-1:0] col1,
  input  logic [PW-1:0] col2,
  output logic [PW-1:0] px_out
);
  function automatic logic [PW-1:0] blend(input code_e c, input logic [PW-1:0] b,
                                          input logic [PW-1:0] k1, input logic [PW-1:0] k2);
    case (c)
      CODE_COL2:   return k2;
      CODE_COL1:   return k1;
      CODE_CLEAR:  return b;
      default:     return ~b;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) px_out <= '0;
    else     px_out <= hit ? blend(code, bg, col1, col2) : bg;
  end
endmodule

// File: rtl/hwcur_overlay.sv
module hwcur_overlay
  import hwcur_pkg::*;
#(
  parameter int COORD_W = hwcur_pkg::COORD_W,
  parameter int PIX_W   = hwcur_pkg::PIX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pat_we,
  input  logic [PAT_AW-1:0]    pat_addr,
  input  logic [BYTE_W-1:0]    pat_wdata,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_sel,
  input  logic [COORD_W-1:0]   cfg_wdata,
  input  logic [COORD_W-1:0]   pan_x,
  input  logic [COORD_W-1:0]   pan_y,
  input  logic [COORD_W-1:0]   beam_x,
  input  logic [COORD_W-1:0]   beam_y,
  input  logic [PIX_W-1:0]     bg_px,
  output logic [PIX_W-1:0]     px_out
);
  localparam int HOT_W = SPR_LOG;

  logic                       en_q;
  logic [PIX_W-1:0]           col1_q, col2_q;
  logic [1:0][HOT_W-1:0]      hot_q;
  logic [1:0][COORD_W-1:0]    pos_q;

  hwcur_cfg #(.CW(COORD_W), .PW(PIX_W), .HW(HOT_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .en_q(en_q), .col1_q(col1_q), .col2_q(col2_q), .hot_q(hot_q), .pos_q(pos_q)
  );

  // stage 0: window test and fetch address
  logic [1:0][COORD_W-1:0]    beam_v, pan_v;
  logic                       hit0;
  logic [1:0][SPR_LOG-1:0]    offs0;
  logic [BANK_AW-1:0]         fetch_idx;

  assign beam_v = {beam_y, beam_x};
  assign pan_v  = {pan_y, pan_x};

  hwcur_window #(.CW(COORD_W), .HW(HOT_W)) u_win (
    .en(en_q), .beam(beam_v), .pos(pos_q), .pan(pan_v), .hot(hot_q),
    .hit(hit0), .offs(offs0)
  );

  assign fetch_idx = bank_index(offs0[1], offs0[0]);

  logic [1:0][BYTE_W-1:0]     plane_byte;

  hwcur_patmem u_mem (
    .clk(clk), .wr_en(pat_we), .wr_addr(pat_addr), .wr_data(pat_wdata),
    .rd_idx(fetch_idx), .rd_q(plane_byte)
  );

  // stage 1: registered window result alongside fetched bytes
  logic                       s1_hit;
  logic [2:0]                 s1_bit;
  logic [PIX_W-1:0]           s1_bg;
  code_e                      s1_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_hit <= 1'b0;
      s1_bit <= '0;
      s1_bg  <= '0;
    end else begin
      s1_hit <= hit0;
      s1_bit <= offs0[0][2:0];
      s1_bg  <= bg_px;
    end
  end

  assign s1_code = code_e'({pick_bit(plane_byte[0], s1_bit), pick_bit(plane_byte[1], s1_bit)});

  // stage 2: compose output
  hwcur_shade #(.PW(PIX_W)) u_shade (
    .clk(clk), .rst(rst), .hit(s1_hit), .code(s1_code), .bg(s1_bg),
    .col1(col1_q), .col2(col2_q), .px_out(px_out)
  );
endmodule

// File: rtl/hwcur_overlay_chk.sv
module hwcur_overlay_chk
  import hwcur_pkg::*;
#(
  parameter int PW = hwcur_pkg::PIX_W
) (
  input logic          clk,
  input logic          rst,
  input logic          en_q,
  input logic          s1_hit,
  input logic [1:0]    s1_code,
  input logic [PW-1:0] s1_bg,
  input logic [PW-1:0] col1_q,
  input logic [PW-1:0] col2_q,
  input logic [PW-1:0] px_out
);
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> px_out == '0);

  a_r4_colour2: assert property (@(posedge clk) disable iff (rst)
    (s1_hit && s1_code == CODE_COL2) |=> px_out == $past(col2_q));

  a_r4_colour1: assert property (@(posedge clk) disable iff (rst)
    (s1_hit && s1_code == CODE_COL1) |=> px_out == $past(col1_q));

  a_r5_transparent: assert property (@(posedge clk) disable iff (rst)
    (s1_hit && s1_code == CODE_CLEAR) |=> px_out == $past(s1_bg));

  a_r6_inverted: assert property (@(posedge clk) disable iff (rst)
    (s1_hit && s1_code == CODE_INVERT) |=> px_out == ~$past(s1_bg));

  a_r7_outside_pass: assert property (@(posedge clk) disable iff (rst)
    !s1_hit |=> px_out == $past(s1_bg));

  a_r8_disabled_no_hit: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !s1_hit);
endmodule

bind hwcur_overlay hwcur_overlay_chk #(.PW(PIX_W)) u_chk (
  .clk(clk), .rst(rst), .en_q(en_q), .s1_hit(s1_hit), .s1_code(s1_code),
  .s1_bg(s1_bg), .col1_q(col1_q), .col2_q(col2_q), .px_out(px_out)
);

// File: tb/hwcur_overlay_tb.sv
module hwcur_overlay_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pat_we = 1'b0;
  logic [9:0]  pat_addr = '0;
  logic [7:0]  pat_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [11:0] cfg_wdata = '0;
  logic [11:0] pan_x = '0, pan_y = '0;
  logic [11:0] beam_x = '0, beam_y = '0;
  logic [7:0]  bg_px = '0;
  logic [7:0]  px_out;

  int checks = 0;
  int failures = 0;

  logic [7:0] pat [1024];
  logic       m_en = 1'b0;
  logic [7:0] m_c1 = '0, m_c2 = '0;
  int         m_hot [2] = '{0, 0};
  int         m_pos [2] = '{0, 0};

  always #5 clk = ~clk;

  hwcur_overlay u_dut (
    .clk(clk), .rst(rst), .pat_we(pat_we), .pat_addr(pat_addr), .pat_wdata(pat_wdata),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pan_x(pan_x), .pan_y(pan_y), .beam_x(beam_x), .beam_y(beam_y),
    .bg_px(bg_px), .px_out(px_out)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // expected pixel from the requirements (R3..R9)
  function automatic logic [7:0] model(input int x, input int y, input logic [7:0] bg,
                                       output string tag);
    int lx, ty, dx, dy, base;
    logic [31:0] w0, w1;
    logic b0, b1;
    lx = m_pos[0] - m_hot[0] - int'(pan_x);
    ty = m_pos[1] - m_hot[1] - int'(pan_y);
    dx = x - lx;
    dy = y - ty;
    if (!m_en) begin tag = "R8"; return bg; end
    if (dx < 0 || dx > 63 || dy < 0 || dy > 63) begin tag = "R7 R9"; return bg; end
    base = dy * 16 + (dx / 32) * 4;
    w0 = {pat[base+3], pat[base+2], pat[base+1], pat[base]};
    w1 = {pat[base+11], pat[base+10], pat[base+9], pat[base+8]};
    b0 = w0[31 - (dx % 32)];
    b1 = w1[31 - (dx % 32)];
    case ({b0, b1})
      2'b00:   begin tag = "R3 R4 colour2"; return m_c2; end
      2'b01:   begin tag = "R3 R4 colour1"; return m_c1; end
      2'b10:   begin tag = "R3 R5";         return bg;   end
      default: begin tag = "R3 R6";         return ~bg;  end
    endcase
  endfunction

  task automatic cfg_write(input logic [2:0] sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 12'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0: m_en = val[0];
      3'd1: m_c1 = val[7:0];
      3'd2: m_c2 = val[7:0];
      3'd3: m_hot[0] = val & 63;
      3'd4: m_hot[1] = val & 63;
      3'd5: m_pos[0] = val & 4095;
      3'd6: m_pos[1] = val & 4095;
      default: ;
    endcase
  endtask

  // stream one beam coordinate per cycle; output checked two edges later (R2)
  // optional pattern write issued with the drive numbered wr_at (R11)
  task automatic sweep(input int x0, input int x1, input int y0, input int y1,
                       input int reps, input string grp,
                       input int wr_at, input int wr_a, input logic [7:0] wr_v);
    int n = 0;
    logic [7:0] e1 = '0, e2 = '0;
    string t1 = "", t2 = "", tg;
    for (int y = y0; y <= y1; y++) begin
      for (int x = x0; x <= x1; x++) begin
        for (int r = 0; r < reps; r++) begin
          logic [7:0] bgv;
          @(negedge clk);
          pat_we = 1'b0;
          if (n >= 2) check(px_out, e2, {"R2 ", grp, " ", t2});
          e2 = e1; t2 = t1;
          bgv = 8'((x * 7 + y * 13 + r * 29) & 255);
          beam_x = 12'(x); beam_y = 12'(y); bg_px = bgv;
          e1 = model(x, y, bgv, tg); t1 = tg;
          if (n == wr_at) begin
            pat_we = 1'b1; pat_addr = 10'(wr_a); pat_wdata = wr_v;
            pat[wr_a] = wr_v;
          end
          n++;
        end
      end
    end
    @(negedge clk);
    pat_we = 1'b0;
    check(px_out, e2, {"R2 ", grp, " ", t2});
    e2 = e1; t2 = t1;
    @(negedge clk);
    check(px_out, e2, {"R2 ", grp, " ", t2});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    string tg;
    logic [7:0] nv;
    int a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(px_out, 8'h00, "R1 reset output");

    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      pat_we = 1'b1; pat_addr = 10'(i);
      pat_wdata = 8'(((i * 89 + 23) ^ (i >> 3) ^ (i * i)) & 255);
      pat[i] = pat_wdata;
    end
    @(negedge clk);
    pat_we = 1'b0;

    // R1 R8: enable clear after reset, position registers zero
    sweep(0, 39, 0, 39, 1, "R1 R8", -1, 0, 8'h00);

    cfg_write(3'd1, 8'h3C);
    cfg_write(3'd2, 8'hA5);
    cfg_write(3'd5, 100);
    cfg_write(3'd6, 50);
    // R8: position set but still disabled
    sweep(95, 110, 48, 60, 1, "R8", -1, 0, 8'h00);
    cfg_write(3'd0, 1);
    sweep(90, 170, 45, 120, 1, "R7", -1, 0, 8'h00);

    // hot spot and panning together
    cfg_write(3'd3, 10);
    cfg_write(3'd4, 7);
    cfg_write(3'd5, 300);
    cfg_write(3'd6, 200);
    @(negedge clk);
    pan_x = 12'd20; pan_y = 12'd5;
    sweep(265, 340, 183, 257, 1, "R7", -1, 0, 8'h00);

    // clipping at top/left, no wrap near coordinate max
    pan_x = 12'd0; pan_y = 12'd0;
    cfg_write(3'd3, 20);
    cfg_write(3'd4, 10);
    cfg_write(3'd5, 5);
    cfg_write(3'd6, 3);
    sweep(0, 60, 0, 60, 1, "R9", -1, 0, 8'h00);
    sweep(4080, 4095, 0, 60, 1, "R9", -1, 0, 8'h00);
    sweep(0, 20, 4070, 4095, 1, "R9", -1, 0, 8'h00);

    // register map: select 7 writes nothing, new colours show
    cfg_write(3'd7, 12'hFFF);
    cfg_write(3'd1, 8'h5A);
    cfg_write(3'd2, 8'hC3);
    cfg_write(3'd3, 0);
    cfg_write(3'd4, 0);
    cfg_write(3'd5, 100);
    cfg_write(3'd6, 50);
    sweep(98, 165, 50, 60, 1, "R10", -1, 0, 8'h00);

    // R11: write the fetched byte in the same cycle as its fetch
    // pixel (dx=9, dy=4): plane0 byte 4*16+0*4+(3-1)=66
    a = 66;
    nv = pat[a] ^ 8'h40;
    sweep(109, 109, 54, 54, 6, "R11", 2, a, nv);
    a = 74;
    nv = pat[a] ^ 8'h40;
    sweep(109, 109, 54, 54, 6, "R11", 3, a, nv);

    // R8: disabling turns the sprite off
    cfg_write(3'd0, 0);
    sweep(100, 163, 50, 55, 1, "R8", -1, 0, 8'h00);

    // R1: reset mid-stream clears output and state
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(px_out, 8'h00, "R1 reset after run");
    m_en = 1'b0; m_c1 = '0; m_c2 = '0;
    m_hot = '{0, 0}; m_pos = '{0, 0};
    cfg_write(3'd0, 1);
    sweep(0, 70, 0, 3, 1, "R1", -1, 0, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule